// File: doc/BRIEF.md
# I2C Line Conditioner and Start/Stop Detector

This block sits between the two open-drain bus pins of an I2C target and the logic that assembles bytes. It runs on a fast system clock and treats the raw clock and data lines as asynchronous. Each line first passes a two-flop synchroniser and then a debounce filter. Together these remove spikes and slow, noisy edges. The filtered clock is then delayed a second time to give a sampling clock. That sampling clock rises well after the data line has settled.

Start and stop conditions are recognised on a slightly delayed copy of the filtered data line, judged against the undelayed filtered clock. A data edge that arrives just before, or together with, the falling clock is therefore seen only after the clock is already low. Such an edge is not mistaken for a start or a stop. Each detection gives a one-cycle pulse and updates a two-bit detection state, which holds until the next detection.

All filter and delay lengths come from one clock-frequency parameter in MHz. A separate parameter can replace the computed data delay when the system clock is slow.

Top module: `i2c_line_frontend`

## Requirements
- R1: After reset, `scl_clean`, `sda_clean` and `scl_sample` are 1, `start_pulse` and `stop_pulse` are 0, and `det_state` is 2'b00 (none).
- R2: When a raw line changes level and holds it, the matching clean output takes the new level exactly 2 + DEB_TICKS clock cycles later, where DEB_TICKS = max(1, (10*CLK_MHZ)/48). This is 12 cycles at the default of 48.
- R3: A raw level that holds for fewer than DEB_TICKS cycles never reaches the clean output. Any return to the old level restarts the count, so the R2 latency is measured from the last change.
- R4: `scl_sample` repeats `scl_clean` delayed by SCL_DLY_TICKS = max(1, (10*CLK_MHZ)/48) cycles. This is 22 cycles after a raw clock change at the default.
- R5: A falling edge of the delayed data line while `scl_clean` is 1 gives a one-cycle `start_pulse` and sets `det_state` to 2'b01. The pulse comes 2 + DEB_TICKS + SDA_DLY_TICKS + 1 cycles after the raw data change, which is 17 at the default.
- R6: A rising edge of the delayed data line while `scl_clean` is 1 gives a one-cycle `stop_pulse`, with the same latency as R5, and sets `det_state` to 2'b10. The two pulses are never high together.
- R7: A data change while the clock is low gives no pulse. A data change that leads a clock fall by SDA_DLY_TICKS raw cycles or fewer (4 at the default) also gives no pulse. A data change that leads the clock fall by one cycle more is detected.
- R8: `det_state` keeps its value in every cycle without a pulse.
- R9: SDA_DLY_TICKS = max(1, (4*CLK_MHZ)/48) unless SDA_DLY_OVR is nonzero, in which case SDA_DLY_OVR is used. At CLK_MHZ = 12 the R2 latency is 4 cycles and the R4 latency is 6 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Raw bus clock line, asynchronous |
| sda_in | input | 1 | Raw bus data line, asynchronous |
| scl_clean | output | 1 | Synchronised and debounced clock line |
| sda_clean | output | 1 | Synchronised and debounced data line |
| scl_sample | output | 1 | Debounced clock line delayed for data sampling |
| start_pulse | output | 1 | One-cycle start indication |
| stop_pulse | output | 1 | One-cycle stop indication |
| det_state | output | 2 | Last detection: 00 none, 01 start, 10 stop |

## Verification
At the default settings, a clean line is due 12 cycles after its raw change and the sampling clock 22 cycles after. A start or stop pulse is due 17 cycles after the raw data edge, and a 12 MHz instance shifts the line outputs to 4 and 6 cycles. The bench counts clock edges and samples at the falling edge. For each line output it checks both the last cycle that must still show the old level and the first cycle that must show the new one. For start and stop, the driver queues each expected pulse with its due cycle. A monitor compares every pulse it sees against the head of that queue, so a pulse that comes early, comes late or is not expected at all is reported. This covers the clock-fall window cases.

// File: rtl/i2cfe_pkg.sv
package i2cfe_pkg;

    typedef enum logic [1:0] {
        DET_NONE  = 2'b00,
        DET_START = 2'b01,
        DET_STOP  = 2'b10
    } det_e;

    // Number of system clocks for a delay of num/48 microseconds at mhz MHz,
    // never less than one.
    function automatic int ticks_min1(input int num, input int mhz);
        int t;
        t = (num * mhz) / 48;
        if (t < 1) begin
            t = 1;
        end
        return t;
    endfunction

endpackage

// File: rtl/i2cfe_sync.sv
module i2cfe_sync #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = din;
        nxt_d.s2 = cur_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dout = cur_q.s2;

endmodule

// File: rtl/i2cfe_debounce.sv
module i2cfe_debounce #(
    parameter int   LEN     = 10,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = (LEN < 2) ? 1 : $clog2(LEN + 1);

    typedef struct packed {
        logic          lvl;
        logic [CW-1:0] cnt;
    } deb_t;

    deb_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (din == cur_q.lvl) begin
            nxt_d.cnt = '0;
        end else if (cur_q.cnt == CW'(LEN - 1)) begin
            nxt_d.lvl = din;
            nxt_d.cnt = '0;
        end else begin
            nxt_d.cnt = cur_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{lvl: RST_VAL, cnt: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dout = cur_q.lvl;

    AST_DEB_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.lvl) |-> (cur_q.lvl == $past(din))); // R2
    AST_DEB_FULL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_q.lvl) |-> ($past(cur_q.cnt) == CW'(LEN - 1))); // R3
    AST_DEB_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < CW'(LEN)); // R3

endmodule

// File: rtl/i2cfe_delay.sv
module i2cfe_delay #(
    parameter int   LEN     = 10,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [LEN-1:0] sr_q, sr_d;

    if (LEN == 1) begin : g_one
        always_comb sr_d = din;
    end else begin : g_many
        always_comb sr_d = {sr_q[LEN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= {LEN{RST_VAL}};
        end else begin
            sr_q <= sr_d;
        end
    end

    assign dout = sr_q[LEN-1];

endmodule

// File: rtl/i2cfe_detect.sv
module i2cfe_detect
    import i2cfe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda_dly,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic [1:0] det_state
);
    typedef struct packed {
        logic sda_prev;
        logic start;
        logic stop;
        det_e st;
    } det_t;

    det_t cur_q, nxt_d;
    logic fell, rose;

    always_comb begin
        fell           = cur_q.sda_prev & ~sda_dly;
        rose           = ~cur_q.sda_prev & sda_dly;
        nxt_d          = cur_q;
        nxt_d.sda_prev = sda_dly;
        nxt_d.start    = scl & fell;
        nxt_d.stop     = scl & rose;
        if (scl & fell) begin
            nxt_d.st = DET_START;
        end else if (scl & rose) begin
            nxt_d.st = DET_STOP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{sda_prev: 1'b1, start: 1'b0, stop: 1'b0, st: DET_NONE};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign start_pulse = cur_q.start;
    assign stop_pulse  = cur_q.stop;
    assign det_state   = cur_q.st;

    AST_START_NEEDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.start |-> ($past(scl) && !$past(sda_dly))); // R5
    AST_STOP_NEEDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.stop |-> ($past(scl) && $past(sda_dly))); // R6
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.start |=> !cur_q.start); // R5
    AST_NO_BOTH_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.start && cur_q.stop)); // R6
    AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_q.start && !cur_q.stop) |-> $stable(cur_q.st)); // R8

endmodule

// File: rtl/i2c_line_frontend.sv
module i2c_line_frontend
    import i2cfe_pkg::*;
#(
    parameter int CLK_MHZ     = 48,
    parameter int SDA_DLY_OVR = 0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_clean,
    output logic       sda_clean,
    output logic       scl_sample,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic [1:0] det_state
);
    localparam int DEB_TICKS     = ticks_min1(10, CLK_MHZ);
    localparam int SCL_DLY_TICKS = ticks_min1(10, CLK_MHZ);
    localparam int SDA_DLY_TICKS = (SDA_DLY_OVR > 0) ? SDA_DLY_OVR : ticks_min1(4, CLK_MHZ);
    localparam int LANES         = 2;

    logic [LANES-1:0] raw_w, sync_w, filt_w;
    logic             sda_dly_w;

    // lane 0 carries the clock line, lane 1 the data line
    assign raw_w = {sda_in, scl_in};

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        i2cfe_sync #(.RST_VAL(1'b1)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[g]),
            .dout (sync_w[g])
        );
        i2cfe_debounce #(.LEN(DEB_TICKS), .RST_VAL(1'b1)) u_deb (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (sync_w[g]),
            .dout (filt_w[g])
        );
    end

    i2cfe_delay #(.LEN(SCL_DLY_TICKS), .RST_VAL(1'b1)) u_scl_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (filt_w[0]),
        .dout (scl_sample)
    );

    i2cfe_delay #(.LEN(SDA_DLY_TICKS), .RST_VAL(1'b1)) u_sda_dly (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (filt_w[1]),
        .dout (sda_dly_w)
    );

    i2cfe_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl        (filt_w[0]),
        .sda_dly    (sda_dly_w),
        .start_pulse(start_pulse),
        .stop_pulse (stop_pulse),
        .det_state  (det_state)
    );

    assign scl_clean = filt_w[0];
    assign sda_clean = filt_w[1];

    AST_PULSE_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (det_state == DET_START)); // R5
    AST_STOP_MATCHES_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> (det_state == DET_STOP)); // R6

endmodule

// File: tb/tb_i2c_line_frontend.sv
module tb_i2c_line_frontend;

    localparam int MHZ     = 48;
    localparam int DEB     = (10 * MHZ) / 48;
    localparam int SCLD    = (10 * MHZ) / 48;
    localparam int SDAD    = (4 * MHZ) / 48;
    localparam int LAT_LN  = 2 + DEB;
    localparam int LAT_SMP = 2 + DEB + SCLD;
    localparam int LAT_EV  = 2 + DEB + SDAD + 1;
    localparam int KIND_START = 1;
    localparam int KIND_STOP  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_raw = 1'b1;
    logic sda_raw = 1'b1;

    logic       scl_clean, sda_clean, scl_sample, start_pulse, stop_pulse;
    logic [1:0] det_state;
    logic       s_scl_clean, s_sda_clean, s_scl_sample, s_start, s_stop;
    logic [1:0] s_det;

    i2c_line_frontend #(.CLK_MHZ(MHZ), .SDA_DLY_OVR(0)) dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_raw), .sda_in(sda_raw),
        .scl_clean(scl_clean), .sda_clean(sda_clean), .scl_sample(scl_sample),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .det_state(det_state)
    );

    i2c_line_frontend #(.CLK_MHZ(12), .SDA_DLY_OVR(0)) dut_slow (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_raw), .sda_in(sda_raw),
        .scl_clean(s_scl_clean), .sda_clean(s_sda_clean), .scl_sample(s_scl_sample),
        .start_pulse(s_start), .stop_pulse(s_stop), .det_state(s_det)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int total = 0;
    int bad = 0;
    bit mon_en = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int    kind;
        int    due;
        string tag;
    } ev_t;
    ev_t exp_q[$];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver: change the raw data line and queue the pulse it must cause
    task automatic drive_sda(input logic v, input int kind, input string tag);
        sda_raw = v;
        if (kind != 0) begin
            exp_q.push_back('{kind: kind, due: cyc + LAT_EV, tag: tag});
        end
    endtask

    // monitor: every pulse must match the head of the queue
    always @(negedge clk) begin
        if (mon_en && (start_pulse || stop_pulse)) begin
            int   kind;
            ev_t  e;
            kind = (start_pulse ? KIND_START : 0) + (stop_pulse ? KIND_STOP : 0);
            if (exp_q.size() == 0) begin
                chk("R7 unexpected pulse", kind, 0);
            end else begin
                e = exp_q.pop_front();
                chk({e.tag, " pulse kind"}, kind, e.kind);
                chk({e.tag, " pulse cycle"}, cyc, e.due);
                chk({e.tag, " det_state at pulse"}, int'(det_state), e.kind);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int c;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        chk("R1 scl_clean", int'(scl_clean), 1);
        chk("R1 sda_clean", int'(sda_clean), 1);
        chk("R1 scl_sample", int'(scl_sample), 1);
        chk("R1 start_pulse", int'(start_pulse), 0);
        chk("R1 stop_pulse", int'(stop_pulse), 0);
        chk("R1 det_state", int'(det_state), 0);
        mon_en = 1'b1;
        step(5);

        // R2, R4, R9: clock line falls
        c = cyc;
        scl_raw = 1'b0;
        for (int k = 1; k <= LAT_SMP; k++) begin
            step(1);
            if (k == LAT_LN - 1)  chk("R2 scl_clean before due", int'(scl_clean), 1);
            if (k == LAT_LN)      chk("R2 scl_clean at due", int'(scl_clean), 0);
            if (k == LAT_SMP - 1) chk("R4 scl_sample before due", int'(scl_sample), 1);
            if (k == LAT_SMP)     chk("R4 scl_sample at due", int'(scl_sample), 0);
            if (k == 3)           chk("R9 slow scl_clean before due", int'(s_scl_clean), 1);
            if (k == 4)           chk("R9 slow scl_clean at due", int'(s_scl_clean), 0);
            if (k == 5)           chk("R9 slow scl_sample before due", int'(s_scl_sample), 1);
            if (k == 6)           chk("R9 slow scl_sample at due", int'(s_scl_sample), 0);
        end
        chk("R2 cycle bookkeeping", cyc, c + LAT_SMP);
        step(10);

        // R7: data falls while clock low, no pulse expected
        drive_sda(1'b0, 0, "R7");
        step(30);
        chk("R7 det_state after low-clock edge", int'(det_state), 0);

        // R2: clock line rises
        scl_raw = 1'b1;
        step(LAT_LN - 1);
        chk("R2 scl_clean rise before due", int'(scl_clean), 0);
        step(1);
        chk("R2 scl_clean rise at due", int'(scl_clean), 1);
        step(20);

        // R6 stop, R5 start
        drive_sda(1'b1, KIND_STOP, "R6");
        step(30);
        chk("R6 det_state after stop", int'(det_state), 2);
        drive_sda(1'b0, KIND_START, "R5");
        step(30);
        chk("R5 det_state after start", int'(det_state), 1);

        // R8: data toggles while clock low, state holds
        scl_raw = 1'b0;
        step(30);
        drive_sda(1'b1, 0, "R8");
        step(20);
        drive_sda(1'b0, 0, "R8");
        step(20);
        chk("R8 det_state held", int'(det_state), 1);
        chk("R8 sda_clean low", int'(sda_clean), 0);

        // R3: short glitch suppressed
        begin
            int seen_high;
            seen_high = 0;
            drive_sda(1'b1, 0, "R3");
            step(DEB - 1);
            drive_sda(1'b0, 0, "R3");
            for (int k = 0; k < 30; k++) begin
                step(1);
                if (sda_clean) seen_high++;
            end
            chk("R3 glitch never reaches sda_clean", seen_high, 0);
        end

        // R3: bounce restarts the count
        drive_sda(1'b1, 0, "R3");
        step(6);
        drive_sda(1'b0, 0, "R3");
        step(1);
        drive_sda(1'b1, 0, "R3");
        step(LAT_LN - 1);
        chk("R3 sda_clean before restarted due", int'(sda_clean), 0);
        step(1);
        chk("R3 sda_clean at restarted due", int'(sda_clean), 1);
        step(20);

        // R7: data leads the clock fall by SDAD cycles, no pulse
        scl_raw = 1'b1;
        step(30);
        drive_sda(1'b0, 0, "R7");
        step(SDAD);
        scl_raw = 1'b0;
        step(30);
        chk("R7 det_state after near-fall edge", int'(det_state), 1);
        drive_sda(1'b1, 0, "R7");
        step(20);
        scl_raw = 1'b1;
        step(30);

        // R7: data leads the clock fall by SDAD+1 cycles, start detected
        drive_sda(1'b0, KIND_START, "R7");
        step(SDAD + 1);
        scl_raw = 1'b0;
        step(30);

        chk("R5 all queued pulses seen", exp_q.size(), 0);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule